// File: doc/BRIEF.md
# Banked Memory Window Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the memories of a small machine. The upper half of the address space (0x8000 to 0xFFFF) always reaches fixed RAM. The lower half is a 32 KB window. A 3-bit bank register chooses what the window shows: base RAM, a 16 KB video RAM, one of five extension RAM banks, or a 16 KB boot ROM. The block turns each CPU access into a physical memory address and one active-low chip select. It also returns the read data of the selected memory, or 0xFF when no memory answers.

A static size input gives the amount of installed main RAM in KB. Each extension bank answers only when that size is large enough. Video RAM and ROM use only their low 14 address bits, so each appears twice in the window. The ROM refuses writes. The bank register is loaded from a parallel port write and comes out of reset pointing at the ROM, so the CPU starts from boot code.

Top module: `bankwin_decoder`

## Requirements
- R1: After reset the bank register holds code 7 (boot ROM), so a read at 0x0000 selects the ROM at physical address 0.
- R2: A cycle with `bank_we` high loads `bank_wdata` into the bank register. An access in that same cycle still uses the old bank. The new bank applies from the next cycle on.
- R3: Any access with address bit 15 set asserts `ram_cs_n` with `mem_addr` equal to the CPU address, whatever the bank.
- R4: Bank code 0 maps a window access to base RAM at `mem_addr` = address bits 14:0.
- R5: Bank code 1 maps a window access to video RAM at `mem_addr` = address bits 13:0, so 0x0200 and 0x4200 reach the same byte.
- R6: Bank code 7 maps window reads to the ROM at `mem_addr` = address bits 13:0. A window write in this bank asserts no chip select and leaves `mem_we_n` high.
- R7: Bank codes 2 to 6 map the window to RAM at physical base 0x10000 + (code-2)*0x8000, ORed with address bits 14:0. The bank is present only when `cfg_ram_kb` is at least 32*(code+1): 96, 128, 160, 192 and 224 KB.
- R8: An access to an absent extension bank asserts no chip select. A read returns 0xFF and a write changes no memory.
- R9: At most one chip select is low in any cycle. None is low while `bus_req` is low.
- R10: Read data from the selected memory appears on `bus_rdata` one cycle after the read request. `bus_rdata` is 0xFF after a cycle with no read.
- R11: `mem_we_n` is low only during a write request that asserts a chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Parallel port write strobe for the bank register |
| bank_wdata | input | 3 | Low 3 bits of the port write, the new bank code |
| cfg_ram_kb | input | 9 | Installed main RAM in KB, held static |
| bus_req | input | 1 | CPU memory access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 16 | CPU address |
| bus_rdata | output | 8 | Read data, returned one cycle after the request |
| mem_addr | output | 18 | Physical address for the selected memory |
| ram_cs_n | output | 1 | Main RAM select, active low |
| vram_cs_n | output | 1 | Video RAM select, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| mem_we_n | output | 1 | Write strobe to the selected memory, active low |
| ram_rdata | input | 8 | Registered read data from main RAM |
| vram_rdata | input | 8 | Registered read data from video RAM |
| rom_rdata | input | 8 | Registered read data from the ROM |

## Verification
A wrong bank register value shows up in the same cycle as the first window access: the wrong chip select goes low, or `mem_addr` carries the wrong base. A wrong registered read selector shows up one cycle later as foreign data or a missing 0xFF. The directed tests place each bank switch right next to an access, cross the extension size thresholds from both sides, and read locations back after discarded writes. This way a dropped or misdirected write shows up as a wrong data value.

// File: rtl/bankwin_pkg.sv
`timescale 1ns/1ps
package bankwin_pkg;

   // bank codes whose position matters to the decode
   localparam int BK_BASE      = 0;
   localparam int BK_VIDEO     = 1;
   localparam int BK_FIRST_EXT = 2;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_RAM  = 2'd1,
      TGT_VRAM = 2'd2,
      TGT_ROM  = 2'd3
   } tgt_e;

endpackage

// File: rtl/bankwin_bank_reg.sv
`timescale 1ns/1ps
module bankwin_bank_reg #(
   parameter int BANK_W     = 3,
   parameter int RESET_BANK = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] din,
   output logic [BANK_W-1:0] bank_q
);

   if (RESET_BANK >= (1 << BANK_W)) begin : g_bad_reset
      $error("RESET_BANK does not fit in BANK_W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bank_q <= BANK_W'(RESET_BANK);
      else if (load) bank_q <= din;
   end

   // R1: reset leaves the boot bank selected
   a_r1_reset_boot: assert property (@(posedge clk)
      !rst_n |=> bank_q == BANK_W'(RESET_BANK));

   // R2: a port write is visible one cycle later
   a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> bank_q == $past(din));

   a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && rst_n) |=> $stable(bank_q));

endmodule

// File: rtl/bankwin_map.sv
`timescale 1ns/1ps
module bankwin_map
   import bankwin_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int PHYS_W      = 18,
   parameter int BANK_W      = 3,
   parameter int SIZE_W      = 9,
   parameter int WIN_KB      = 32,
   parameter int BASE_RAM_KB = 64,
   parameter int VID_AW      = 14,
   parameter int ROM_AW      = 14
) (
   input  logic [BANK_W-1:0] bank,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] cfg_kb,
   output tgt_e              tgt,
   output logic [PHYS_W-1:0] phys
);

   localparam int NBANK   = 1 << BANK_W;
   localparam int BOOT    = NBANK - 1;
   localparam int WIN_AW  = ADDR_W - 1;
   localparam int N_EXT   = BOOT - BK_FIRST_EXT;
   localparam int TOP_KB  = BASE_RAM_KB + N_EXT * WIN_KB;

   if (WIN_KB * 1024 != (1 << WIN_AW)) begin : g_bad_win
      $error("window size must be half of the address space");
   end
   if (VID_AW > WIN_AW || ROM_AW > WIN_AW) begin : g_bad_mirror
      $error("video or ROM span exceeds the window");
   end
   if ((1 << PHYS_W) < TOP_KB * 1024) begin : g_bad_phys
      $error("PHYS_W too narrow for the highest extension bank");
   end
   if ((1 << SIZE_W) <= TOP_KB) begin : g_bad_size
      $error("SIZE_W too narrow for the largest RAM size");
   end

   logic [NBANK-1:0]  present;
   logic [PHYS_W-1:0] base [NBANK];

   for (genvar k = 0; k < NBANK; k++) begin : g_bank
      if (k >= BK_FIRST_EXT && k < BOOT) begin : g_ext
         localparam int START_KB = BASE_RAM_KB + (k - BK_FIRST_EXT) * WIN_KB;
         assign present[k] = (cfg_kb >= SIZE_W'(START_KB + WIN_KB));
         assign base[k]    = PHYS_W'(START_KB * 1024);
      end else begin : g_fixed
         assign present[k] = 1'b1;
         assign base[k]    = '0;
      end
   end

   always_comb begin
      tgt  = TGT_NONE;
      phys = '0;
      if (req) begin
         if (addr[ADDR_W-1]) begin
            tgt  = TGT_RAM;
            phys = PHYS_W'(addr);
         end else if (bank == BANK_W'(BK_BASE)) begin
            tgt  = TGT_RAM;
            phys = PHYS_W'(addr[WIN_AW-1:0]);
         end else if (bank == BANK_W'(BK_VIDEO)) begin
            tgt  = TGT_VRAM;
            phys = PHYS_W'(addr[VID_AW-1:0]);
         end else if (bank == BANK_W'(BOOT)) begin
            if (!we) begin
               tgt  = TGT_ROM;
               phys = PHYS_W'(addr[ROM_AW-1:0]);
            end
         end else if (present[bank]) begin
            tgt  = TGT_RAM;
            phys = base[bank] | PHYS_W'(addr[WIN_AW-1:0]);
         end
      end
   end

endmodule

// File: rtl/bankwin_rdmux.sv
`timescale 1ns/1ps
module bankwin_rdmux
   import bankwin_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_now,
   input  tgt_e              tgt,
   input  logic [DATA_W-1:0] ram_rd,
   input  logic [DATA_W-1:0] vram_rd,
   input  logic [DATA_W-1:0] rom_rd,
   output logic [DATA_W-1:0] rdata
);

   tgt_e sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= TGT_NONE;
      else        sel_q <= rd_now ? tgt : TGT_NONE;
   end

   always_comb begin
      case (sel_q)
         TGT_RAM:  rdata = ram_rd;
         TGT_VRAM: rdata = vram_rd;
         TGT_ROM:  rdata = rom_rd;
         default:  rdata = '1;
      endcase
   end

   // R10: the return path follows the memory chosen one cycle earlier
   a_r10_vram_return: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && tgt == TGT_VRAM) |=> rdata == vram_rd);

endmodule

// File: rtl/bankwin_decoder.sv
`timescale 1ns/1ps
module bankwin_decoder
   import bankwin_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int PHYS_W      = 18,
   parameter int DATA_W      = 8,
   parameter int BANK_W      = 3,
   parameter int SIZE_W      = 9,
   parameter int WIN_KB      = 32,
   parameter int BASE_RAM_KB = 64,
   parameter int VID_AW      = 14,
   parameter int ROM_AW      = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wdata,
   input  logic [SIZE_W-1:0] cfg_ram_kb,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [PHYS_W-1:0] mem_addr,
   output logic              ram_cs_n,
   output logic              vram_cs_n,
   output logic              rom_cs_n,
   output logic              mem_we_n,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] vram_rdata,
   input  logic [DATA_W-1:0] rom_rdata
);

   localparam int BOOT_BANK = (1 << BANK_W) - 1;

   logic [BANK_W-1:0] bank_q;
   tgt_e              tgt;

   bankwin_bank_reg #(
      .BANK_W     (BANK_W),
      .RESET_BANK (BOOT_BANK)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (bank_we),
      .din    (bank_wdata),
      .bank_q (bank_q)
   );

   bankwin_map #(
      .ADDR_W      (ADDR_W),
      .PHYS_W      (PHYS_W),
      .BANK_W      (BANK_W),
      .SIZE_W      (SIZE_W),
      .WIN_KB      (WIN_KB),
      .BASE_RAM_KB (BASE_RAM_KB),
      .VID_AW      (VID_AW),
      .ROM_AW      (ROM_AW)
   ) u_map (
      .bank   (bank_q),
      .req    (bus_req),
      .we     (bus_we),
      .addr   (bus_addr),
      .cfg_kb (cfg_ram_kb),
      .tgt    (tgt),
      .phys   (mem_addr)
   );

   bankwin_rdmux #(
      .DATA_W (DATA_W)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_now  (bus_req && !bus_we),
      .tgt     (tgt),
      .ram_rd  (ram_rdata),
      .vram_rd (vram_rdata),
      .rom_rd  (rom_rdata),
      .rdata   (bus_rdata)
   );

   assign ram_cs_n  = (tgt != TGT_RAM);
   assign vram_cs_n = (tgt != TGT_VRAM);
   assign rom_cs_n  = (tgt != TGT_ROM);
   assign mem_we_n  = !(bus_we && tgt != TGT_NONE);

   // R9: one select at most, none when idle
   a_r9_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~ram_cs_n, ~vram_cs_n, ~rom_cs_n}));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (ram_cs_n && vram_cs_n && rom_cs_n));

   // R3: upper half is fixed RAM at the CPU address
   a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_addr[ADDR_W-1]) |-> (!ram_cs_n && mem_addr == PHYS_W'(bus_addr)));

   // R6: the ROM never sees a write
   a_r6_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> rom_cs_n);

   // R8: an unanswered read returns all ones
   a_r8_absent_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && ram_cs_n && vram_cs_n && rom_cs_n) |=> bus_rdata == '1);

   // R10: ROM read data arrives one cycle after the request
   a_r10_rom_return: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && !rom_cs_n) |=> bus_rdata == rom_rdata);

   // R11: write strobe only with a selected memory
   a_r11_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (bus_req && bus_we && !(ram_cs_n && vram_cs_n && rom_cs_n)));

endmodule

// File: tb/bankwin_decoder_tb.sv
`timescale 1ns/1ps
module bankwin_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bank_we = 1'b0;
   logic [2:0]  bank_wdata = '0;
   logic [8:0]  cfg_ram_kb = 9'd224;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [17:0] mem_addr;
   logic        ram_cs_n, vram_cs_n, rom_cs_n, mem_we_n;
   logic [7:0]  ram_q = '0, vram_q = '0, rom_q = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   bankwin_decoder u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bank_we    (bank_we),
      .bank_wdata (bank_wdata),
      .cfg_ram_kb (cfg_ram_kb),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_rdata  (bus_rdata),
      .mem_addr   (mem_addr),
      .ram_cs_n   (ram_cs_n),
      .vram_cs_n  (vram_cs_n),
      .rom_cs_n   (rom_cs_n),
      .mem_we_n   (mem_we_n),
      .ram_rdata  (ram_q),
      .vram_rdata (vram_q),
      .rom_rdata  (rom_q)
   );

   // ---------------- memory models ----------------
   logic [7:0] ram_w  [int];
   logic [7:0] vram_w [int];

   function automatic logic [7:0] ram_pat(int a);
      return 8'((a * 7) + ((a >> 8) * 3) + ((a >> 16) * 29));
   endfunction
   function automatic logic [7:0] vram_pat(int a);
      return 8'(a ^ (a >> 8) ^ 8'hC3);
   endfunction
   function automatic logic [7:0] rom_pat(int a);
      return 8'(a ^ (a >> 6) ^ 8'h3C);
   endfunction

   function automatic logic [7:0] ram_peek(int a);
      return ram_w.exists(a) ? ram_w[a] : ram_pat(a);
   endfunction
   function automatic logic [7:0] vram_peek(int a);
      return vram_w.exists(a) ? vram_w[a] : vram_pat(a);
   endfunction

   always @(posedge clk) begin
      if (!ram_cs_n) begin
         if (!mem_we_n) ram_w[int'(mem_addr)] = bus_wdata;
         else           ram_q <= ram_peek(int'(mem_addr));
      end
      if (!vram_cs_n) begin
         if (!mem_we_n) vram_w[int'(mem_addr)] = bus_wdata;
         else           vram_q <= vram_peek(int'(mem_addr));
      end
      if (!rom_cs_n) rom_q <= rom_pat(int'(mem_addr));
   end

   // ---------------- helpers ----------------
   localparam logic [2:0] CS_NONE = 3'b000, CS_RAM = 3'b100,
                          CS_VRAM = 3'b010, CS_ROM = 3'b001;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] cs_vec();
      return {~ram_cs_n, ~vram_cs_n, ~rom_cs_n};
   endfunction

   function automatic logic [7:0] expect_data(logic [2:0] cs, int phys);
      case (cs)
         CS_RAM:  return ram_peek(phys);
         CS_VRAM: return vram_peek(phys);
         CS_ROM:  return rom_pat(phys);
         default: return 8'hFF;
      endcase
   endfunction

   task automatic set_bank(logic [2:0] b);
      @(negedge clk);
      bank_we = 1'b1; bank_wdata = b;
      @(negedge clk);
      bank_we = 1'b0;
   endtask

   task automatic do_rd(string tag, logic [15:0] a, logic [2:0] exp_cs, int exp_phys);
      logic [7:0] exp_d;
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      chk({tag, " select"}, 32'(cs_vec()), 32'(exp_cs));
      if (exp_cs != CS_NONE) chk({tag, " address"}, 32'(mem_addr), 32'(exp_phys));
      exp_d = expect_data(exp_cs, exp_phys);
      @(negedge clk);
      bus_req = 1'b0;
      chk({tag, " data"}, 32'(bus_rdata), 32'(exp_d));
   endtask

   task automatic do_wr(string tag, logic [15:0] a, logic [7:0] d,
                        logic [2:0] exp_cs, int exp_phys);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      chk({tag, " wr select"}, 32'(cs_vec()), 32'(exp_cs));
      chk({tag, " wr strobe"}, 32'(mem_we_n), (exp_cs == CS_NONE) ? 32'd1 : 32'd0);
      if (exp_cs != CS_NONE) chk({tag, " wr address"}, 32'(mem_addr), 32'(exp_phys));
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk("R9 idle selects in reset", 32'(cs_vec()), 32'(CS_NONE));
      chk("R10 rdata idle in reset", 32'(bus_rdata), 32'hFF);
      @(negedge clk);
      rst_n = 1'b1;
      do_rd("R1 boot read 0x0000", 16'h0000, CS_ROM, 'h0000);
      do_rd("R6 rom mirror 0x4005", 16'h4005, CS_ROM, 'h0005);
      @(negedge clk);
      chk("R9 idle selects", 32'(cs_vec()), 32'(CS_NONE));
      chk("R11 idle strobe", 32'(mem_we_n), 32'd1);
   endtask

   task automatic t_rom_write();
      do_wr("R6 rom write dropped", 16'h0010, 8'h99, CS_NONE, 0);
      do_rd("R6 rom intact", 16'h0010, CS_ROM, 'h0010);
   endtask

   task automatic t_upper();
      do_rd("R3 upper read in boot bank", 16'h8123, CS_RAM, 'h08123);
      do_wr("R3 upper write", 16'hC000, 8'h5A, CS_RAM, 'h0C000);
      do_rd("R3 upper readback", 16'hC000, CS_RAM, 'h0C000);
   endtask

   task automatic t_switch_timing();
      logic [7:0] exp_d;
      @(negedge clk);
      bank_we = 1'b1; bank_wdata = 3'd0;
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'h0100;
      #1;
      chk("R2 old bank in load cycle", 32'(cs_vec()), 32'(CS_ROM));
      exp_d = rom_pat('h0100);
      @(negedge clk);
      bank_we = 1'b0; bus_req = 1'b0;
      chk("R2 old bank data", 32'(bus_rdata), 32'(exp_d));
      do_rd("R2 R4 new bank read", 16'h0100, CS_RAM, 'h00100);
   endtask

   task automatic t_base();
      do_wr("R4 base write", 16'h1234, 8'hA5, CS_RAM, 'h01234);
      do_rd("R4 base readback", 16'h1234, CS_RAM, 'h01234);
      do_rd("R4 base top of window", 16'h7FFF, CS_RAM, 'h07FFF);
   endtask

   task automatic t_vram();
      set_bank(3'd1);
      do_wr("R5 vram write", 16'h0200, 8'h77, CS_VRAM, 'h0200);
      do_rd("R5 vram mirror read", 16'h4200, CS_VRAM, 'h0200);
      chk("R5 mirror data value", 32'(vram_peek('h0200)), 32'h77);
      do_rd("R3 upper in video bank", 16'hFFFF, CS_RAM, 'h0FFFF);
   endtask

   task automatic t_ext_full();
      cfg_ram_kb = 9'd224;
      for (int k = 2; k <= 6; k++) begin
         set_bank(3'(k));
         do_rd($sformatf("R7 ext bank %0d read", k), 16'h7001, CS_RAM,
               'h10000 + (k - 2) * 'h8000 + 'h7001);
      end
      set_bank(3'd3);
      do_wr("R7 ext bank 3 write", 16'h0003, 8'h3E, CS_RAM, 'h18003);
      do_rd("R7 ext bank 3 readback", 16'h0003, CS_RAM, 'h18003);
   endtask

   task automatic t_absent();
      cfg_ram_kb = 9'd96;
      set_bank(3'd2);
      do_rd("R7 bank 2 present at 96", 16'h0040, CS_RAM, 'h10040);
      set_bank(3'd3);
      do_rd("R8 bank 3 absent read", 16'h0050, CS_NONE, 0);
      do_wr("R8 bank 3 absent write", 16'h0050, 8'hEE, CS_NONE, 0);
      cfg_ram_kb = 9'd95;
      set_bank(3'd2);
      do_rd("R8 bank 2 absent at 95", 16'h0040, CS_NONE, 0);
      cfg_ram_kb = 9'd223;
      set_bank(3'd6);
      do_rd("R8 bank 6 absent at 223", 16'h0001, CS_NONE, 0);
      cfg_ram_kb = 9'd224;
      do_rd("R7 bank 6 present at 224", 16'h0001, CS_RAM, 'h30001);
      set_bank(3'd3);
      do_rd("R8 absent write left memory", 16'h0050, CS_RAM, 'h18050);
      chk("R8 memory untouched", 32'(ram_peek('h18050)), 32'(ram_pat('h18050)));
   endtask

   // ---------------- run ----------------
   initial begin
      t_reset();
      t_rom_write();
      t_upper();
      t_switch_timing();
      t_base();
      t_vram();
      t_ext_full();
      t_absent();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule